// File: doc/BRIEF.md
# Flash Hardware Reset and Ready/Busy Sequencer

This block turns the active-low hardware reset pin of a flash device into the internal control that stops work in progress and brings the device back to a usable state. The pin is first synchronised to the clock. It is then qualified: it must stay low for a minimum number of cycles before it counts as a reset, so short glitches do nothing. When a reset is accepted, the block gives the embedded program/erase engine a one-cycle abort pulse. It holds the command decoder in read-array mode and tells the bus interface to tri-state the data pins and drop every read and write.

How long recovery takes depends on whether the algorithm engine was busy at the moment the reset was accepted. In that case the block pulls the open-drain ready/busy line low for an internal reset period. After the line is released, it waits a further recovery period before access is allowed again. If the engine was idle, the ready/busy line is never pulled. The internal reset finishes after a short fixed period, and access returns a hold period after the filtered pin has gone high. An aborted operation is never resumed: the engine only sees the abort, and the host must issue the command sequence again.

Top module: `rst_ready_seq`

## Requirements
- R1: The reset pin counts as a reset only after its synchronised level has been low for MIN_PULSE consecutive cycles. A shorter low pulse causes no change on any output. With SYNC_STAGES synchroniser flops, the reset is accepted in the (MIN_PULSE+SYNC_STAGES)-th cycle after the pin falls.
- R2: `abort_pulse` is high for exactly one cycle, the cycle in which the reset is accepted, and never again for that same reset.
- R3: `force_read_mode` is high from the cycle after acceptance until the internal reset phase ends. That phase lasts T_READY cycles on the busy path, and on the idle path lasts until both T_RP cycles have passed and the filtered pin is high.
- R4: `bus_ignore` is high from the acceptance cycle through the later of two points: the end of the internal reset phase and the last cycle in which the filtered reset is still asserted.
- R5: If `algo_busy` was 1 in the acceptance cycle, `rb_drive_low` (1 pulls the ready/busy line low) is high for exactly T_READY cycles, starting the cycle after acceptance, regardless of how long the pin stays low.
- R6: On the busy path, `access_en` returns T_RB cycles after `rb_drive_low` falls, or one cycle after the filtered reset deasserts, whichever is later.
- R7: If `algo_busy` was 0 in the acceptance cycle, `rb_drive_low` stays 0 throughout. `access_en` returns T_RH cycles after the internal reset phase ends.
- R8: After power-on reset `access_en` is 1 and all other outputs are 0. `access_en` is 0 in every cycle from the cycle after acceptance until recovery completes.
- R9: `algo_busy` is sampled only in the acceptance cycle. A change on it later during the same reset does not change the recovery path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset of the sequencer, active low |
| reset_pin_n | input | 1 | Asynchronous hardware reset pin, active low |
| algo_busy | input | 1 | 1 while the embedded program/erase engine is running |
| abort_pulse | output | 1 | One-cycle request to terminate the running algorithm |
| force_read_mode | output | 1 | Holds the command decoder in read-array mode |
| bus_ignore | output | 1 | Tri-state the data bus and discard all bus cycles |
| rb_drive_low | output | 1 | Enable of the open-drain pull-down on ready/busy |
| access_en | output | 1 | Bus accesses are permitted |

## Verification
The two events that can fall in the same cycle are the end of the internal reset timer and the release of the filtered reset pin. Either one may be the one that ends the phase. The bench sweeps the pin's low width over every value from below the qualification minimum to well past the longest timer, on both the busy and the idle path. This makes the release land before, exactly on, and after the timer's expiry. For each width, the expected edges of every output are computed as a maximum of the two arrival times and compared with the cycle counts measured at the ports. On the idle path the busy flag is raised after acceptance, to show that the path chosen at acceptance holds.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE         = 2'd0,
    ST_IN_RESET     = 2'd1,
    ST_BUSY_RECOVER = 2'd2,
    ST_WAIT_ACCESS  = 2'd3
  } seq_state_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic rst_qual,
  output logic rst_rise
);
  import rst_seq_pkg::*;

  localparam int CW = width_for(MIN_PULSE);
  localparam logic [CW-1:0] SAT = CW'(MIN_PULSE);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [CW-1:0]          low_cnt;
  logic                   qual_d;

  // synchroniser chain, idles at the inactive (high) level
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sync_q <= '1;
    end else begin
      sync_q[0] <= pin_n;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  // saturating count of consecutive low samples
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              low_cnt <= '0;
    else if (pin_s)          low_cnt <= '0;
    else if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
  end

  assign rst_qual = (low_cnt == SAT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) qual_d <= 1'b0;
    else        qual_d <= rst_qual;
  end

  assign rst_rise = rst_qual & ~qual_d;

  // R1: a released pin withdraws the qualified reset on the next cycle
  p_release_drops_qual_r1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(pin_s) |=> !rst_qual);

  // R1: acceptance only ever follows a low sample
  p_accept_after_low_r1: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_qual) |-> $past(!pin_s));

endmodule

// File: rtl/rst_delay_counter.sv
module rst_delay_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm #(
  parameter int T_READY = 1000,
  parameter int T_RB    = 2,
  parameter int T_RP    = 25,
  parameter int T_RH    = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_qual,
  input  logic rst_rise,
  input  logic algo_busy,
  output logic abort_pulse,
  output logic force_read_mode,
  output logic bus_ignore,
  output logic rb_drive_low,
  output logic access_en
);
  import rst_seq_pkg::*;

  localparam int TMAX = max_of4(T_READY, T_RB, T_RP, T_RH);
  localparam int CW   = width_for(TMAX);
  localparam logic [CW-1:0] LD_READY = CW'(T_READY - 1);
  localparam logic [CW-1:0] LD_RB    = CW'(T_RB - 1);
  localparam logic [CW-1:0] LD_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] LD_RH    = CW'(T_RH - 1);

  seq_state_e    state_q, state_d;
  logic          was_busy_q;
  logic          capture;
  logic          cnt_load;
  logic [CW-1:0] cnt_val;
  logic          expired;

  rst_delay_counter #(.W(CW)) u_timer (
    .clk      (clk),
    .por_n    (por_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (expired)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    if (rst_rise && state_q != ST_IN_RESET) begin
      state_d  = ST_IN_RESET;
      cnt_load = 1'b1;
      cnt_val  = algo_busy ? LD_READY : LD_RP;
      capture  = 1'b1;
    end else begin
      unique case (state_q)
        ST_IN_RESET: begin
          if (expired) begin
            if (was_busy_q) begin
              state_d  = ST_BUSY_RECOVER;
              cnt_load = 1'b1;
              cnt_val  = LD_RB;
            end else if (!rst_qual) begin
              state_d  = ST_WAIT_ACCESS;
              cnt_load = 1'b1;
              cnt_val  = LD_RH;
            end
          end
        end
        ST_BUSY_RECOVER: if (expired && !rst_qual) state_d = ST_IDLE;
        ST_WAIT_ACCESS:  if (expired) state_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q    <= ST_IDLE;
      was_busy_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (capture) was_busy_q <= algo_busy;
    end
  end

  assign abort_pulse     = rst_rise && (state_q != ST_IN_RESET);
  assign force_read_mode = (state_q == ST_IN_RESET);
  assign bus_ignore      = rst_qual || (state_q == ST_IN_RESET);
  assign rb_drive_low    = (state_q == ST_IN_RESET) && was_busy_q;
  assign access_en       = (state_q == ST_IDLE);

  // R2: abort lasts a single cycle
  p_abort_one_cycle_r2: assert property (@(posedge clk) disable iff (!por_n)
    abort_pulse |=> !abort_pulse);

  // R3: read-array mode is forced right after an abort
  p_abort_forces_read_r3: assert property (@(posedge clk) disable iff (!por_n)
    abort_pulse |=> force_read_mode);

  // R8: no access while a qualified reset is present
  p_no_access_in_reset_r8: assert property (@(posedge clk) disable iff (!por_n)
    rst_qual |=> !access_en);

  // R6: release of ready/busy is followed by a recovery gap, not access
  p_recover_gap_r6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rb_drive_low) |-> !access_en);

  // R7: the hold phase only runs with the pin released
  p_hold_after_release_r7: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_WAIT_ACCESS) |-> (!rst_qual || rst_rise));

endmodule

// File: rtl/rst_ready_seq.sv
module rst_ready_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 16,
  parameter int T_READY     = 1000,
  parameter int T_RB        = 2,
  parameter int T_RP        = 25,
  parameter int T_RH        = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic reset_pin_n,
  input  logic algo_busy,
  output logic abort_pulse,
  output logic force_read_mode,
  output logic bus_ignore,
  output logic rb_drive_low,
  output logic access_en
);
  logic rst_qual;
  logic rst_rise;

  rst_pin_filter #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_PULSE   (MIN_PULSE)
  ) u_filter (
    .clk      (clk),
    .por_n    (por_n),
    .pin_n    (reset_pin_n),
    .rst_qual (rst_qual),
    .rst_rise (rst_rise)
  );

  rst_seq_fsm #(
    .T_READY (T_READY),
    .T_RB    (T_RB),
    .T_RP    (T_RP),
    .T_RH    (T_RH)
  ) u_fsm (
    .clk             (clk),
    .por_n           (por_n),
    .rst_qual        (rst_qual),
    .rst_rise        (rst_rise),
    .algo_busy       (algo_busy),
    .abort_pulse     (abort_pulse),
    .force_read_mode (force_read_mode),
    .bus_ignore      (bus_ignore),
    .rb_drive_low    (rb_drive_low),
    .access_en       (access_en)
  );

  // R5: ready/busy is only pulled while read mode is forced
  p_rb_inside_reset_r5: assert property (@(posedge clk) disable iff (!por_n)
    rb_drive_low |-> (force_read_mode && bus_ignore && !access_en));

endmodule

// File: tb/tb_rst_ready_seq.sv
module tb_rst_ready_seq;
  localparam int CLK_PERIOD = 10;
  localparam int S   = 2;
  localparam int M   = 3;
  localparam int TR  = 6;
  localparam int TRB = 2;
  localparam int TRP = 2;
  localparam int TRH = 3;
  localparam int WIN = 40;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic reset_pin_n = 1'b1;
  logic algo_busy = 1'b0;
  logic abort_pulse, force_read_mode, bus_ignore, rb_drive_low, access_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_ready_seq #(
    .SYNC_STAGES (S), .MIN_PULSE (M), .T_READY (TR),
    .T_RB (TRB), .T_RP (TRP), .T_RH (TRH)
  ) dut (
    .clk (clk), .por_n (por_n), .reset_pin_n (reset_pin_n),
    .algo_busy (algo_busy), .abort_pulse (abort_pulse),
    .force_read_mode (force_read_mode), .bus_ignore (bus_ignore),
    .rb_drive_low (rb_drive_low), .access_en (access_en)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_case(input int busy, input int low_len);
    int abort_cnt = 0, abort_first = -1, rb_cnt = 0, rb_first = -1;
    int force_cnt = 0, ign_cnt = 0, acc_low = 0, acc_first = -1;
    int q, x, exp_acc, exp_force, exp_ign;
    @(negedge clk);
    algo_busy   = busy[0];
    reset_pin_n = 1'b0;
    q = M + S;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      if (abort_pulse) begin abort_cnt++; if (abort_first < 0) abort_first = k; end
      if (rb_drive_low) begin rb_cnt++; if (rb_first < 0) rb_first = k; end
      if (force_read_mode) force_cnt++;
      if (bus_ignore) ign_cnt++;
      if (!access_en) acc_low++;
      else if (acc_low > 0 && acc_first < 0) acc_first = k;
      if (k == low_len) reset_pin_n = 1'b1;
      if (k == q + 1) algo_busy = busy[0] ? 1'b0 : 1'b1;
    end
    algo_busy = 1'b0;
    if (low_len < M) begin
      chk($sformatf("R1 glitch len=%0d abort", low_len), abort_cnt, 0);
      chk($sformatf("R1 glitch len=%0d ignore", low_len), ign_cnt, 0);
      chk($sformatf("R1 glitch len=%0d access", low_len), acc_low, 0);
      chk($sformatf("R1 glitch len=%0d rb", low_len), rb_cnt, 0);
    end else begin
      chk($sformatf("R2 abort count busy=%0d len=%0d", busy, low_len), abort_cnt, 1);
      chk($sformatf("R1 accept cycle busy=%0d len=%0d", busy, low_len), abort_first, q);
      if (busy != 0) begin
        x         = q + TR;
        exp_force = TR;
        exp_ign   = imax(low_len + S, x) - q + 1;
        exp_acc   = imax(x + TRB, low_len + S + 1) + 1;
        chk($sformatf("R5 rb cycles len=%0d", low_len), rb_cnt, TR);
        chk($sformatf("R5 rb start len=%0d", low_len), rb_first, q + 1);
        chk($sformatf("R6 access return len=%0d", low_len), acc_first, exp_acc);
      end else begin
        x         = imax(q + TRP, low_len + S + 1);
        exp_force = x - q;
        exp_ign   = x - q + 1;
        exp_acc   = x + TRH + 1;
        chk($sformatf("R7 R9 rb quiet len=%0d", low_len), rb_cnt, 0);
        chk($sformatf("R7 access return len=%0d", low_len), acc_first, exp_acc);
      end
      chk($sformatf("R3 read force cycles busy=%0d len=%0d", busy, low_len), force_cnt, exp_force);
      chk($sformatf("R4 ignore cycles busy=%0d len=%0d", busy, low_len), ign_cnt, exp_ign);
      chk($sformatf("R8 access low cycles busy=%0d len=%0d", busy, low_len), acc_low, exp_acc - (q + 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset access_en", int'(access_en), 1);
    chk("R8 reset abort_pulse", int'(abort_pulse), 0);
    chk("R8 reset rb_drive_low", int'(rb_drive_low), 0);
    chk("R8 reset bus_ignore", int'(bus_ignore), 0);
    chk("R8 reset force_read_mode", int'(force_read_mode), 0);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int b = 0; b < 2; b++)
      for (int len = 1; len <= 12; len++)
        run_case(b, len);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule